// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup Engine

This block resolves a destination address to a next-hop code by longest-prefix match. It does the match with two direct memory reads and no search. The upper address bits index a first-level table. Every entry there either gives the next hop at once, or names a second-level block. That block is then indexed by the remaining low address bits and always yields a next hop. Routes no longer than the split point are expanded by software into the first level. Longer routes live in second-level blocks. The block itself does not perform that expansion; software installs the expanded entries through a plain write port.

The two reads form a pipeline, so a lookup can start every clock and results come out in request order after a fixed latency. The address width, the split point, the number of second-level blocks and the next-hop width are all parameters. A full-size instance uses 32 address bits split 24+8. The defaults are a small 12-bit address split 8+4, which keeps elaboration cheap and lets a bench compare every address against a linear-search model. Both tables are on-chip synchronous RAMs with no reset, and their contents survive a reset of the pipeline.

Top module: `route_lookup`

## Requirements
- R1: Each response carries the next hop of the longest installed prefix that covers the requested address, once software has written the expanded tables.
- R2: A first-level entry has a flag in its top bit (bit PAY_W of the entry). When the flag is 0, the low NH_W bits of the entry are returned as the next hop, and second-level contents have no effect on that lookup.
- R3: When the flag is 1, the low BLK_W bits of the entry select a second-level block. The result is that block's entry at the index formed by the block number (upper bits) concatenated with the low ADDR_W-HI_W address bits (lower bits).
- R4: A request presented in cycle t produces rsp_valid in cycle t+2 and in no other cycle. Back-to-back requests give back-to-back responses in request order.
- R5: During reset, and in the two cycles after reset, rsp_valid stays 0. A reset also discards lookups that are in flight.
- R6: An address covered by no prefix returns the reserved no-route code that software stored in the default entries (all ones in the bench).
- R7: With wr_en=1, wr_tbl=0 writes wr_data to first-level entry wr_idx[HI_W-1:0]. wr_tbl=1 writes wr_data[NH_W-1:0] to second-level entry wr_idx[BLK_W+LO_W-1:0]. A lookup presented in the cycle after the write sees the new value.
- R8: Writes may be issued in any cycle, including cycles that carry lookups. Lookups whose entries are not being written keep returning correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the pipeline valids |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Destination address to resolve |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_hop | output | NH_W | Resolved next-hop code |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | Write target: 0 first level, 1 second level |
| wr_idx | input | max(HI_W, BLK_W+ADDR_W-HI_W) | Entry index within the chosen table |
| wr_data | input | max(NH_W, BLK_W)+1 | Entry value; first level is {flag, payload} |

## Verification
The checks assume that every table entry a lookup can reach has been written before that lookup is issued, so table reads and results are never unknown. They also assume that the write strobe, the target select and the index are never unknown while a write is active. Finally, they assume that no lookup reads an entry in the same cycle that entry is being rewritten. The stimulus programs the complete first level, and every second-level block it points to, before the first lookup. During the concurrent-write scenario it only rewrites entries that no in-flight lookup depends on. The one test of write visibility issues its lookup a full cycle after the write.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic {
    TBL_FIRST  = 1'b0,
    TBL_SECOND = 1'b1
  } tbl_sel_e;

  function automatic int lpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lpm_sdp_ram.sv
module lpm_sdp_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  AST_RD_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    re |-> !$isunknown(raddr)) else $error("read index unknown"); // R3

  AST_WR_ADDR_KNOWN: assert property (@(posedge clk) disable iff (rst)
    we |-> !$isunknown(waddr)) else $error("write index unknown"); // R7

endmodule

// File: rtl/lpm_resolve.sv
module lpm_resolve #(
  parameter int NH_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_ptr,
  input  logic [NH_W-1:0] in_hop,
  input  logic [NH_W-1:0] l2_hop,
  output logic            out_valid,
  output logic [NH_W-1:0] out_hop
);
  logic            ptr_q;
  logic [NH_W-1:0] hop_q;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    ptr_q <= in_ptr;
    hop_q <= in_hop;
  end

  always_comb begin
    out_hop = ptr_q ? l2_hop : hop_q;
  end

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_hop)) else $error("result unknown"); // R1

endmodule

// File: rtl/route_lookup.sv
module route_lookup
  import lpm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int HI_W   = 8,
  parameter int BLK_W  = 4,
  parameter int NH_W   = 8,
  localparam int LO_W  = ADDR_W - HI_W,
  localparam int L2_AW = BLK_W + LO_W,
  localparam int PAY_W = lpm_max(NH_W, BLK_W),
  localparam int ENT_W = PAY_W + 1,
  localparam int IDX_W = lpm_max(HI_W, L2_AW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [NH_W-1:0]   rsp_hop,
  input  logic              wr_en,
  input  logic              wr_tbl,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ENT_W-1:0]  wr_data
);

  logic             l1_we, l2_we;
  logic [ENT_W-1:0] l1_q;
  logic [NH_W-1:0]  l2_q;
  logic             s1_valid;
  logic [LO_W-1:0]  s1_lo;
  logic             l1_ptr;
  logic [BLK_W-1:0] l1_blk;
  logic [NH_W-1:0]  l1_hop;
  logic [L2_AW-1:0] l2_raddr;

  always_comb begin
    l1_we    = wr_en && (tbl_sel_e'(wr_tbl) == TBL_FIRST);
    l2_we    = wr_en && (tbl_sel_e'(wr_tbl) == TBL_SECOND);
    l1_ptr   = l1_q[ENT_W-1];
    l1_blk   = l1_q[BLK_W-1:0];
    l1_hop   = l1_q[NH_W-1:0];
    l2_raddr = {l1_blk, s1_lo};
  end

  // stage 1: first-level read, carry the low address bits alongside
  lpm_sdp_ram #(.AW(HI_W), .DW(ENT_W)) u_l1 (
    .clk   (clk),
    .rst   (rst),
    .we    (l1_we),
    .waddr (wr_idx[HI_W-1:0]),
    .wdata (wr_data),
    .re    (req_valid),
    .raddr (req_addr[ADDR_W-1 -: HI_W]),
    .rdata (l1_q)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    s1_lo <= req_addr[LO_W-1:0];
  end

  // stage 2: second-level read only when the entry is a pointer
  lpm_sdp_ram #(.AW(L2_AW), .DW(NH_W)) u_l2 (
    .clk   (clk),
    .rst   (rst),
    .we    (l2_we),
    .waddr (wr_idx[L2_AW-1:0]),
    .wdata (wr_data[NH_W-1:0]),
    .re    (s1_valid && l1_ptr),
    .raddr (l2_raddr),
    .rdata (l2_q)
  );

  lpm_resolve #(.NH_W(NH_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s1_valid),
    .in_ptr    (l1_ptr),
    .in_hop    (l1_hop),
    .l2_hop    (l2_q),
    .out_valid (rsp_valid),
    .out_hop   (rsp_hop)
  );

  // cycles since reset, saturating; used only by the checks below
  logic [1:0] warm_cnt;
  always_ff @(posedge clk) begin
    if (rst)                   warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  AST_LAT_TWO: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt == 2'd2) |-> (rsp_valid == $past(req_valid, 2))) else $error("latency"); // R4

  AST_QUIET_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    (warm_cnt != 2'd2) |-> !rsp_valid) else $error("early response"); // R5

  AST_L1_ENTRY_KNOWN: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> !$isunknown(l1_q)) else $error("first-level entry unknown"); // R2

  AST_WR_CTRL_KNOWN: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$isunknown(wr_tbl)) else $error("write target unknown"); // R7

endmodule

// File: tb/sim_route_lookup.sv
`timescale 1ns/1ps
module sim_route_lookup;

  localparam int ADDR_W = 12;
  localparam int NH_W   = 8;
  localparam logic [7:0] NO_ROUTE = 8'hFF;
  localparam int NP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_hop;
  logic        wr_en = 1'b0;
  logic        wr_tbl = 1'b0;
  logic [7:0]  wr_idx = '0;
  logic [8:0]  wr_data = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [11:0] pv [0:NP-1];
  int          pl [0:NP-1];
  logic [7:0]  ph [0:NP-1];
  int          blk_of [0:255];

  always #2 clk = ~clk;

  route_lookup u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hop(rsp_hop), .wr_en(wr_en), .wr_tbl(wr_tbl),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [7:0] ref_lpm(input logic [11:0] a);
    int best = -1;
    logic [7:0] hop = NO_ROUTE;
    for (int k = 0; k < NP; k++) begin
      logic [11:0] m = 12'hFFF << (12 - pl[k]);
      if (((a & m) == (pv[k] & m)) && pl[k] > best) begin
        best = pl[k];
        hop  = ph[k];
      end
    end
    return hop;
  endfunction

  function automatic bit needs_block(input int i);
    for (int k = 0; k < NP; k++)
      if (pl[k] > 8 && int'(pv[k][11:4]) == i) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tbl_write(input bit t, input logic [7:0] idx, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = t; wr_idx = idx; wr_data = d;
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup_one(input logic [11:0] a, input logic [7:0] exp, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_hop == exp, rq, int'(rsp_hop), int'(exp));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rsp_valid, "R5 in reset", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid, "R5 after reset c1", int'(rsp_valid), 0);
    @(negedge clk);
    chk(!rsp_valid, "R5 after reset c2", int'(rsp_valid), 0);
  endtask

  // software prefix expansion, then installation through the write port (R7)
  task automatic t_program();
    int blk = 0;
    for (int i = 0; i < 256; i++) begin
      blk_of[i] = -1;
      if (needs_block(i)) begin
        for (int j = 0; j < 16; j++)
          tbl_write(1'b1, {blk[3:0], j[3:0]}, {1'b0, ref_lpm({i[7:0], j[3:0]})});
        tbl_write(1'b0, i[7:0], {1'b1, 4'h0, blk[3:0]});
        blk_of[i] = blk;
        blk++;
      end else begin
        tbl_write(1'b0, i[7:0], {1'b0, ref_lpm({i[7:0], 4'h0})});
      end
    end
    wr_idle();
  endtask

  task automatic t_latency();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'hA4C;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid, "R4 not at t+1", int'(rsp_valid), 0);
    @(negedge clk);
    chk(rsp_valid && rsp_hop == 8'h05, "R4 at t+2", int'(rsp_hop), 5);
    @(negedge clk);
    chk(!rsp_valid, "R4 not at t+3", int'(rsp_valid), 0);
  endtask

  task automatic t_sweep();
    for (int s = 0; s < 4098; s++) begin
      @(negedge clk);
      if (s >= 2) begin
        logic [7:0] e = ref_lpm(12'(s - 2));
        chk(rsp_valid, "R4 back-to-back valid", int'(rsp_valid), 1);
        chk(rsp_hop == e, "R1 sweep", int'(rsp_hop), int'(e));
      end
      if (s < 4096) begin
        req_valid = 1'b1; req_addr = 12'(s);
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  task automatic t_no_route();
    lookup_one(12'h500, NO_ROUTE, "R6 no route 0x500");
    lookup_one(12'h000, NO_ROUTE, "R6 no route 0x000");
    lookup_one(12'h7FF, NO_ROUTE, "R6 no route 0x7FF");
    lookup_one(12'hA4D, 8'h03, "R1 falls back to /8");
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'hA4C;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!rsp_valid, "R5 in-flight dropped", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rsp_valid, "R5 quiet after mid reset", int'(rsp_valid), 0);
    lookup_one(12'hA4C, 8'h05, "R5 tables survive reset");
  endtask

  // lookups stream while unrelated entries are rewritten every cycle (R8)
  task automatic t_live_writes();
    logic [11:0] qa [0:31];
    for (int s = 0; s < 34; s++) begin
      @(negedge clk);
      if (s >= 2) begin
        logic [7:0] e = ref_lpm(qa[s-2]);
        chk(rsp_valid && rsp_hop == e, "R8 stream during writes", int'(rsp_hop), int'(e));
      end
      if (s < 32) begin
        qa[s] = (s % 2 == 0) ? (12'hA40 + 12'(s % 16)) : (12'h3F0 + 12'(s % 16));
        req_valid = 1'b1; req_addr = qa[s];
        wr_en = 1'b1;
        if (s % 4 == 3) begin
          wr_tbl = 1'b0; wr_idx = 8'h55; wr_data = {1'b0, 8'(s)};
        end else begin
          wr_tbl = 1'b1; wr_idx = {4'hF, 4'(s)}; wr_data = {1'b0, 8'h40 + 8'(s)};
        end
      end else begin
        req_valid = 1'b0; wr_en = 1'b0;
      end
    end
  endtask

  task automatic t_flag_modes();
    for (int j = 0; j < 16; j++)
      tbl_write(1'b1, {4'hF, j[3:0]}, {1'b0, 8'h60 + 8'(j)});
    tbl_write(1'b0, 8'h55, {1'b0, 8'h0F});
    wr_idle();
    lookup_one(12'h555, 8'h0F, "R2 flag 0 returns payload");
    lookup_one(12'h55A, 8'h0F, "R2 flag 0 ignores low bits");
    tbl_write(1'b0, 8'h55, {1'b1, 8'h0F});
    wr_idle();
    lookup_one(12'h555, 8'h65, "R3 pointer into block 15");
    lookup_one(12'h55A, 8'h6A, "R3 low bits index block");
  endtask

  task automatic t_write_visible();
    int b = blk_of[8'hA4];
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = 1'b1; wr_idx = {b[3:0], 4'hC}; wr_data = {1'b0, 8'h77};
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_addr = 12'hA4C;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_hop == 8'h77, "R7 write seen next cycle", int'(rsp_hop), 8'h77);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    pv[0] = 12'h800; pl[0] = 1;  ph[0] = 8'h01;
    pv[1] = 12'hA00; pl[1] = 4;  ph[1] = 8'h02;
    pv[2] = 12'hA40; pl[2] = 8;  ph[2] = 8'h03;
    pv[3] = 12'hA48; pl[3] = 10; ph[3] = 8'h04;
    pv[4] = 12'hA4C; pl[4] = 12; ph[4] = 8'h05;
    pv[5] = 12'h300; pl[5] = 5;  ph[5] = 8'h06;
    pv[6] = 12'h3F0; pl[6] = 12; ph[6] = 8'h07;
    pv[7] = 12'h340; pl[7] = 9;  ph[7] = 8'h08;
    pv[8] = 12'h0F0; pl[8] = 6;  ph[8] = 8'h09;
    pv[9] = 12'h0F8; pl[9] = 11; ph[9] = 8'h0A;
    t_reset();
    t_program();
    t_latency();
    t_sweep();
    t_no_route();
    t_reset_mid();
    t_live_writes();
    t_flag_modes();
    t_write_visible();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule